// File: doc/BRIEF.md
# Write-Through Pixel Data Cache With Snoop Invalidation

This block is the private first-level data cache that sits between one compute core and a shared, byte-addressed video memory. The core issues single-byte reads and writes. Reads that find their line present return a byte one cycle after acceptance. Reads that miss fetch the whole eight-byte line from memory before answering. Every write is passed on to memory. A write that finds its line present also updates the local copy. A write that misses leaves the cache contents unchanged.

Several such caches share the memory through an arbiter that lives outside this block. That arbiter raises `mem_req_ready` as the grant. The memory returns read data exactly one cycle after a read request is accepted. Each cache also listens to a broadcast of the writes made by the other cores. If such a write lands in a line this cache holds, the line is dropped, and the next read of it goes back to memory.

The core request channel and the memory request channel are valid/ready. A request is taken on a clock edge where valid and ready are both high. While valid is high and ready is low, the sender holds the request and all its fields unchanged. `core_rsp_valid` and `mem_rsp_valid` are one-cycle pulses with no back-pressure: the receiver must take the data in the cycle it appears.

Top module: `pixcache_l1`

## Requirements
- R1: After reset every line is invalid, `core_req_ready` is high, and `core_rsp_valid` and `mem_req_valid` are low. The first read of any address after reset is a miss.
- R2: Address bits [2:0] select the byte within a line, bits [8:3] select one of 64 lines, and the bits above form the tag. A fill issues eight byte reads of the line, in order from byte offset 0 to byte offset 7.
- R3: A read hit keeps `core_req_ready` high, makes no memory request, and raises `core_rsp_valid` one cycle after acceptance.
- R4: On a read miss, `core_req_ready` stays low until the fill ends. The response then carries the addressed byte as memory held it.
- R5: When a fill completes without interference, the line becomes valid with its tag. Later reads of any byte in that line hit.
- R6: Every accepted write produces one memory write with the same address and byte (`mem_req_we`=1). `core_req_ready` stays low until the memory accepts it. A write hit also updates the cached byte.
- R7: A write miss does not allocate a line, so a later read of that address misses.
- R8: A snoop whose address lies in a valid line with a matching tag invalidates that line, and the next read of it refetches. A snoop with a different tag for the same line index has no effect.
- R9: A snoop that matches the line being filled lets the fill and its response complete, but the line is left invalid.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request fields stay unchanged. Results are correct under any grant pattern.
- R11: Two addresses with the same line index but different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Cache can take a core request |
| core_req_we | input | 1 | 1 = write, 0 = read |
| core_req_addr | input | ADDR_W | Byte address |
| core_req_wdata | input | DATA_W | Write byte |
| core_rsp_valid | output | 1 | Read data pulse |
| core_rsp_rdata | output | DATA_W | Read byte |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Arbiter grant / accept |
| mem_req_we | output | 1 | 1 = write-through, 0 = fill read |
| mem_req_addr | output | ADDR_W | Memory byte address |
| mem_req_wdata | output | DATA_W | Memory write byte |
| mem_rsp_valid | input | 1 | Fill byte returned, one cycle after read acceptance |
| mem_rsp_rdata | input | DATA_W | Fill byte |
| snoop_valid | input | 1 | Another core wrote memory |
| snoop_addr | input | ADDR_W | Address that other core wrote |

## Verification
The checks inside the design assume the following about the inputs:
- The memory sends exactly one `mem_rsp_valid` pulse, one cycle after each accepted read, and never answers a write.
- The core holds its request steady while ready is low.

The bench memory model answers in exactly that way. The bench drives core requests only at falling edges and holds them until acceptance. It exercises the grant both held high and alternating every cycle. Snoops come from the bench alone, sometimes with a matching memory change and sometimes spurious, and one snoop is placed in the middle of a fill.

// File: rtl/pixcache_pkg.sv
package pixcache_pkg;
  // Controller sequencing states.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_FILL  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/pixcache_tags.sv
module pixcache_tags #(
  parameter int LINES = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             sn_valid,
  input  logic [IDX_W-1:0] sn_idx,
  input  logic [TAG_W-1:0] sn_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] sn_kill;
  logic             sn_hit;

  // Per-line snoop match: another core wrote inside this line.
  for (genvar g = 0; g < LINES; g++) begin : g_snoop
    assign sn_kill[g] = sn_valid && (sn_idx == IDX_W'(g)) && (tag_q[g] == sn_tag);
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign sn_hit = valid_q[sn_idx] && (tag_q[sn_idx] == sn_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (set_en && set_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= set_tag;
        end
        if ((clr_en && clr_idx == IDX_W'(i)) || sn_kill[i]) valid_q[i] <= 1'b0;
      end
    end
  end

  // R8: a snoop that hits a valid line leaves it invalid.
  a_r8_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sn_valid && sn_hit |=> !valid_q[$past(sn_idx)]);
endmodule

// File: rtl/pixcache_data.sv
module pixcache_data #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [OFF_W-1:0]  woff,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  input  logic [OFF_W-1:0]  roff,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << (IDX_W + OFF_W);
  logic [DATA_W-1:0] bytes_q [DEPTH];

  assign rdata = bytes_q[{ridx, roff}];

  always_ff @(posedge clk) begin
    if (we) bytes_q[{widx, woff}] <= wdata;
  end
endmodule

// File: rtl/pixcache_ctrl.sv
module pixcache_ctrl
  import pixcache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic              core_req_we,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_rsp_valid,
  output logic [DATA_W-1:0] core_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              lk_hit,
  output logic              clr_en,
  output logic [IDX_W-1:0]  clr_idx,
  output logic              set_en,
  output logic [IDX_W-1:0]  set_idx,
  output logic [ADDR_W-OFF_W-IDX_W-1:0] set_tag,
  output logic              d_we,
  output logic [IDX_W-1:0]  d_widx,
  output logic [OFF_W-1:0]  d_woff,
  output logic [DATA_W-1:0] d_wdata,
  input  logic [DATA_W-1:0] d_rdata
);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam logic [OFF_W-1:0] LAST_OFF = '1;

  ctl_state_e        state_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_wdata_q;
  logic [OFF_W-1:0]  req_cnt_q, rsp_cnt_q;
  logic              req_done_q, poison_q;
  logic [DATA_W-1:0] cap_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic              accept, fill_last, snoop_on_fill;
  logic [OFF_W-1:0]  core_off, pend_off;
  logic [IDX_W-1:0]  core_idx, pend_idx, snp_idx;
  logic [TAG_W-1:0]  pend_tag, snp_tag;

  assign core_off = core_req_addr[OFF_W-1:0];
  assign core_idx = core_req_addr[OFF_W +: IDX_W];
  assign pend_off = pend_addr_q[OFF_W-1:0];
  assign pend_idx = pend_addr_q[OFF_W +: IDX_W];
  assign pend_tag = pend_addr_q[ADDR_W-1 -: TAG_W];
  assign snp_idx  = snoop_addr[OFF_W +: IDX_W];
  assign snp_tag  = snoop_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    core_req_ready = (state_q == ST_IDLE);
    accept         = core_req_valid && core_req_ready;
    clr_en         = accept && !core_req_we && !lk_hit;
    clr_idx        = core_idx;
    mem_req_valid  = 1'b0;
    mem_req_we     = 1'b0;
    mem_req_addr   = pend_addr_q;
    mem_req_wdata  = pend_wdata_q;
    d_we           = 1'b0;
    d_widx         = core_idx;
    d_woff         = core_off;
    d_wdata        = core_req_wdata;
    case (state_q)
      ST_IDLE: d_we = accept && core_req_we && lk_hit;
      ST_WRITE: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
      end
      ST_FILL: begin
        mem_req_valid = !req_done_q;
        mem_req_addr  = {pend_tag, pend_idx, req_cnt_q};
        d_we          = mem_rsp_valid;
        d_widx        = pend_idx;
        d_woff        = rsp_cnt_q;
        d_wdata       = mem_rsp_rdata;
      end
      default: ;
    endcase
    fill_last     = (state_q == ST_FILL) && mem_rsp_valid && (rsp_cnt_q == LAST_OFF);
    snoop_on_fill = (state_q == ST_FILL) && snoop_valid &&
                    (snp_idx == pend_idx) && (snp_tag == pend_tag);
    set_en        = fill_last && !poison_q && !snoop_on_fill;
    set_idx       = pend_idx;
    set_tag       = pend_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      req_cnt_q    <= '0;
      rsp_cnt_q    <= '0;
      req_done_q   <= 1'b0;
      poison_q     <= 1'b0;
      cap_q        <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_data_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            pend_addr_q  <= core_req_addr;
            pend_wdata_q <= core_req_wdata;
            if (core_req_we) begin
              state_q <= ST_WRITE;
            end else if (lk_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= d_rdata;
            end else begin
              state_q    <= ST_FILL;
              req_cnt_q  <= '0;
              rsp_cnt_q  <= '0;
              req_done_q <= 1'b0;
              poison_q   <= 1'b0;
            end
          end
        end
        ST_WRITE: begin
          if (mem_req_ready) state_q <= ST_IDLE;
        end
        ST_FILL: begin
          if (mem_req_valid && mem_req_ready) begin
            if (req_cnt_q == LAST_OFF) req_done_q <= 1'b1;
            else                       req_cnt_q  <= req_cnt_q + 1'b1;
          end
          if (snoop_on_fill) poison_q <= 1'b1;
          if (mem_rsp_valid) begin
            rsp_cnt_q <= rsp_cnt_q + 1'b1;
            if (rsp_cnt_q == pend_off) cap_q <= mem_rsp_rdata;
            if (rsp_cnt_q == LAST_OFF) begin
              state_q     <= ST_IDLE;
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= (pend_off == LAST_OFF) ? mem_rsp_rdata : cap_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign core_rsp_valid = rsp_valid_q;
  assign core_rsp_rdata = rsp_data_q;

  // R10: an ungranted memory request is held unchanged.
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R6: an accepted write shows up as a memory write of the same address.
  a_r6_wr_forward: assert property (@(posedge clk) disable iff (!rst_n)
    accept && core_req_we |=> mem_req_valid && mem_req_we
      && (mem_req_addr == $past(core_req_addr)));

  // R3: a read that hits answers in the next cycle.
  a_r3_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !core_req_we && lk_hit |=> core_rsp_valid);

  // R4: fill data arrives only while a fill is in progress.
  a_r4_rsp_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> state_q == ST_FILL);
endmodule

// File: rtl/pixcache_l1.sv
module pixcache_l1 #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic              core_req_we,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_rsp_valid,
  output logic [DATA_W-1:0] core_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic              lk_hit, clr_en, set_en, d_we;
  logic [IDX_W-1:0]  clr_idx, set_idx, d_widx;
  logic [TAG_W-1:0]  set_tag;
  logic [OFF_W-1:0]  d_woff;
  logic [DATA_W-1:0] d_wdata, d_rdata;

  pixcache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_ctrl (
    .clk, .rst_n,
    .core_req_valid, .core_req_ready, .core_req_we, .core_req_addr, .core_req_wdata,
    .core_rsp_valid, .core_rsp_rdata,
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_rdata,
    .snoop_valid, .snoop_addr,
    .lk_hit, .clr_en, .clr_idx, .set_en, .set_idx, .set_tag,
    .d_we, .d_widx, .d_woff, .d_wdata, .d_rdata
  );

  pixcache_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n,
    .lk_idx  (core_req_addr[OFF_W +: IDX_W]),
    .lk_tag  (core_req_addr[ADDR_W-1 -: TAG_W]),
    .lk_hit,
    .sn_valid(snoop_valid),
    .sn_idx  (snoop_addr[OFF_W +: IDX_W]),
    .sn_tag  (snoop_addr[ADDR_W-1 -: TAG_W]),
    .clr_en, .clr_idx, .set_en, .set_idx, .set_tag
  );

  pixcache_data #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk,
    .we   (d_we),
    .widx (d_widx),
    .woff (d_woff),
    .wdata(d_wdata),
    .ridx (core_req_addr[OFF_W +: IDX_W]),
    .roff (core_req_addr[OFF_W-1:0]),
    .rdata(d_rdata)
  );
endmodule

// File: tb/pixcache_l1_test.sv
module pixcache_l1_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // Row: {req id[31:28], op[27:26] (0 read,1 write,2 snoop+mem change,3 spurious snoop),
  //       expect hit[25], pad[24], addr[23:12], pad[11:8], data[7:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd4,  2'd0, 1'b0, 1'b0, 12'h045, 4'h0, 8'h00},  // R4 cold miss
    {4'd3,  2'd0, 1'b1, 1'b0, 12'h047, 4'h0, 8'h00},  // R3 hit same line
    {4'd6,  2'd1, 1'b0, 1'b0, 12'h045, 4'h0, 8'h3C},  // R6 write hit
    {4'd6,  2'd0, 1'b1, 1'b0, 12'h045, 4'h0, 8'h00},  // R6 local byte updated
    {4'd7,  2'd1, 1'b0, 1'b0, 12'h100, 4'h0, 8'h77},  // R7 write miss
    {4'd7,  2'd0, 1'b0, 1'b0, 12'h100, 4'h0, 8'h00},  // R7 no allocation
    {4'd11, 2'd0, 1'b0, 1'b0, 12'h245, 4'h0, 8'h00},  // R11 same index other tag
    {4'd11, 2'd0, 1'b0, 1'b0, 12'h045, 4'h0, 8'h00},  // R11 evicted
    {4'd8,  2'd2, 1'b0, 1'b0, 12'h046, 4'h0, 8'h99},  // R8 other core writes
    {4'd8,  2'd0, 1'b0, 1'b0, 12'h046, 4'h0, 8'h00},  // R8 refetch
    {4'd8,  2'd3, 1'b0, 1'b0, 12'h245, 4'h0, 8'h00},  // R8 tag mismatch snoop
    {4'd8,  2'd0, 1'b1, 1'b0, 12'h045, 4'h0, 8'h00},  // R8 still valid
    {4'd5,  2'd0, 1'b1, 1'b0, 12'h040, 4'h0, 8'h00},  // R5 byte 0
    {4'd5,  2'd0, 1'b1, 1'b0, 12'h047, 4'h0, 8'h00}   // R5 byte 7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_req_valid = 1'b0, core_req_we = 1'b0;
  logic [11:0] core_req_addr = '0;
  logic [7:0]  core_req_wdata = '0;
  logic        core_req_ready, core_rsp_valid;
  logic [7:0]  core_rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [11:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_rdata = '0;
  logic        snoop_valid = 1'b0;
  logic [11:0] snoop_addr = '0;
  logic        stall_mode = 1'b0;
  logic [7:0]  bmem [4096];
  int          cyc = 0, nrd = 0, nwr = 0, order_err = 0;
  logic [2:0]  exp_off = '0;
  int          nchk = 0, nerr = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_req_ready = !stall_mode || cyc[0];

  pixcache_l1 uut (
    .clk, .rst_n, .core_req_valid, .core_req_ready, .core_req_we, .core_req_addr,
    .core_req_wdata, .core_rsp_valid, .core_rsp_rdata, .mem_req_valid, .mem_req_ready,
    .mem_req_we, .mem_req_addr, .mem_req_wdata, .mem_rsp_valid, .mem_rsp_rdata,
    .snoop_valid, .snoop_addr
  );

  // Shared memory model: one-cycle read latency, fill order monitor.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        bmem[mem_req_addr] <= mem_req_wdata;
        nwr <= nwr + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= bmem[mem_req_addr];
        nrd <= nrd + 1;
        if (mem_req_addr[2:0] != exp_off) order_err <= order_err + 1;
        exp_off <= exp_off + 3'd1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_read(input logic [11:0] a, input bit exp_hit, input string rq, input bit snp);
    logic [7:0] exp;
    int rd0, lat;
    exp = bmem[a];
    rd0 = nrd;
    @(negedge clk);
    core_req_valid = 1'b1; core_req_we = 1'b0; core_req_addr = a;
    while (!core_req_ready) @(negedge clk);
    @(negedge clk);
    core_req_valid = 1'b0;
    lat = 1;
    while (!core_rsp_valid && lat < 200) begin
      if (snp && lat == 3) begin
        snoop_valid = 1'b1; snoop_addr = a ^ 12'h002;
      end else snoop_valid = 1'b0;
      @(negedge clk);
      lat++;
    end
    snoop_valid = 1'b0;
    chk(core_rsp_rdata == exp, rq, "read data", core_rsp_rdata, exp);
    chk((lat == 1 && nrd == rd0) == exp_hit, rq, "hit (1) or miss (0)",
        (lat == 1 && nrd == rd0), exp_hit);
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d, input string rq);
    int wr0, w;
    wr0 = nwr;
    @(negedge clk);
    core_req_valid = 1'b1; core_req_we = 1'b1; core_req_addr = a; core_req_wdata = d;
    while (!core_req_ready) @(negedge clk);
    @(negedge clk);
    core_req_valid = 1'b0;
    w = 0;
    while (!core_req_ready && w < 200) begin
      @(negedge clk);
      w++;
    end
    chk(bmem[a] == d, rq, "memory byte after write", bmem[a], d);
    chk(nwr == wr0 + 1, rq, "memory write count", nwr - wr0, 1);
  endtask

  task automatic do_snoop(input logic [11:0] a);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) bmem[i] = 8'(i * 7 + 3) ^ 8'(i >> 4);
    do_reset();
    // R1 reset state at the ports
    chk(core_req_ready == 1'b1, "R1", "ready after reset", core_req_ready, 1);
    chk(core_rsp_valid == 1'b0, "R1", "rsp valid after reset", core_rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1", "mem valid after reset", mem_req_valid, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [3:0]  rid;
      logic [1:0]  op;
      logic        eh;
      logic [11:0] a;
      logic [7:0]  d;
      string       rq;
      rid = VEC[v][31:28]; op = VEC[v][27:26]; eh = VEC[v][25];
      a = VEC[v][23:12]; d = VEC[v][7:0];
      rq = $sformatf("R%0d row %0d", rid, v);
      case (op)
        2'd0: do_read(a, eh, rq, 1'b0);
        2'd1: do_write(a, d, rq);
        2'd2: begin @(negedge clk); bmem[a] = d; do_snoop(a); end
        default: do_snoop(a);
      endcase
    end

    // R9: snoop in the middle of a fill of the same line
    do_read(12'h300, 1'b0, "R9 fill with snoop", 1'b1);
    do_read(12'h300, 1'b0, "R9 line left invalid", 1'b0);
    do_read(12'h305, 1'b1, "R9 clean refill", 1'b0);

    // R10: grant alternates every cycle
    stall_mode = 1'b1;
    do_read(12'h580, 1'b0, "R10 miss under stalls", 1'b0);
    do_write(12'h581, 8'h5A, "R10 write under stalls");
    do_read(12'h581, 1'b1, "R10 hit after stalled write", 1'b0);
    stall_mode = 1'b0;

    // R2 fill byte order across all fills
    chk(order_err == 0, "R2", "out-of-order fill reads", order_err, 0);

    // R1: reset mid-run empties the cache
    do_reset();
    chk(core_req_ready == 1'b1, "R1", "ready after second reset", core_req_ready, 1);
    do_read(12'h045, 1'b0, "R1 miss after reset", 1'b0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule